// File: doc/BRIEF.md
# Serial Save-Memory Slave

This block stands in for the nonvolatile save memory of a cartridge, seen from the host as an SPI slave that swaps one byte per transfer. The host raises `sel` to open a command. It then offers bytes one at a time on `byte_in` with a one-cycle `byte_valid` pulse. One cycle later the slave answers with `byte_done` and the reply on `byte_out`. The first byte of a command is the opcode. Read and write opcodes are followed by a big-endian address, and the data phase then streams bytes through an internal RAM with an address that advances after each byte.

The parameter `FLASH_MODE` picks the address length: two address bytes in EEPROM mode (0) and three in flash mode (1). The status byte holds only a write-enable latch. Writes land only while that latch is set. Each transferred byte carries a `hold` flag. A byte sent with `hold` low is the last byte of its command, and dropping `sel` also ends the command.

The controller moves through six named states:
- IDLE waits for an opcode.
- ADDR collects the address bytes.
- READ streams stored bytes back to the host.
- WRITE stores incoming bytes.
- STATUS repeats the status byte.
- NOP absorbs bytes of latch-only or unknown opcodes.

Transitions:
- IDLE→ADDR on opcode 0x02 or 0x03.
- IDLE→STATUS on 0x05.
- IDLE→NOP on any other opcode.
- ADDR→READ or ADDR→WRITE after the last address byte.
- Any state returns to IDLE on a byte sent with `hold` low, or when `sel` falls.

Top module: `spi_save_mem`

## Requirements
- R1: The first byte accepted in IDLE is latched as the opcode and clears the address accumulator. The reply to the opcode byte is 0xFF. Opcodes other than 0x02, 0x03, 0x04, 0x05 and 0x06 make every further byte of that command return 0xFF.
- R2: Opcodes 0x02 and 0x03 are followed by address bytes, most significant first. There are 2 address bytes when FLASH_MODE=0 and 3 when FLASH_MODE=1. Each address byte returns 0xFF.
- R3: Opcode 0x06 sets bit 1 of the status byte and opcode 0x04 clears it. After opcode 0x05, every further byte of the command returns the status byte, whose bits other than bit 1 are zero.
- R4: In a read (0x03) data phase, each byte returns the stored byte at the current address, and the address then increments.
- R5: In a write (0x02) data phase, each byte is stored at the current address only when status bit 1 is set, and the address then increments. Each such byte returns 0xFF. With bit 1 clear, memory is left unchanged.
- R6: Status bit 1 clears when a write command ends, whether by a `hold`-low byte or by `sel` falling.
- R7: A location never written since reset reads as 0xFF.
- R8: The address wraps modulo MEM_DEPTH. Address bits above log2(MEM_DEPTH) are ignored.
- R9: A byte sent with `hold` low ends its command, so the next byte is taken as a new opcode. `sel` falling also ends the command.
- R10: A `byte_valid` pulse while `sel` is low is ignored: no `byte_done` and no change of state or status.
- R11: `byte_done` pulses for exactly one cycle, in the cycle after an accepted byte. After reset, `byte_done` is 0 and `byte_out` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| hold | input | 1 | Keep the command open after this byte |
| byte_valid | input | 1 | One-cycle pulse offering `byte_in` |
| byte_in | input | 8 | Byte from host |
| byte_out | output | 8 | Reply byte, valid with `byte_done` |
| byte_done | output | 1 | Transfer complete strobe |

## Verification
The hardest case to reach is the clearing of the latch when a write ends abruptly. It requires a write opcode and a complete address under a set latch, then releasing `sel` before any data byte, and only a later status read can show the result. The bench builds that sequence explicitly. It also runs sweeps of wrapping writes on a 16-entry array in both address modes, with addresses whose high bits are set so that they must be discarded. After each sweep it reads the whole array back against an arithmetic model.

// File: rtl/spi_save_pkg.sv
package spi_save_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_STATUS,
        ST_NOP
    } sv_state_e;

    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] FILL     = 8'hFF;
endpackage

// File: rtl/spi_save_ram.sv
module spi_save_ram
    import spi_save_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0]       cells [DEPTH];
    logic [DEPTH-1:0] written;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     written       <= '0;
        else if (wr_en) written[addr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) cells[addr] <= wdata;
    end

    assign rdata = written[addr] ? cells[addr] : FILL;

    // R5: a stored byte is readable at the same address on the next cycle
    p_store_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (addr != $past(addr) || rdata == $past(wdata)));
endmodule

// File: rtl/spi_save_ctrl.sv
module spi_save_ctrl
    import spi_save_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int AW         = 8,
    localparam int ACC_W     = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          hold,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    input  logic [7:0]    mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [7:0]    byte_out,
    output logic          byte_done
);
    sv_state_e        state, state_n;
    logic [7:0]       cmd, cmd_n, cmd_eff, tx_n;
    logic [ACC_W-1:0] acc, acc_n;
    logic [1:0]       cnt, cnt_n;
    logic             wel, wel_n, take;

    assign take      = sel && byte_valid;
    assign cmd_eff   = (state == ST_IDLE) ? byte_in : cmd;
    assign mem_addr  = acc[AW-1:0];
    assign mem_wdata = byte_in;

    always_comb begin
        state_n = state;
        cmd_n   = cmd;
        acc_n   = acc;
        cnt_n   = cnt;
        wel_n   = wel;
        tx_n    = FILL;
        mem_we  = 1'b0;
        if (!sel) begin
            state_n = ST_IDLE;
            if (state != ST_IDLE && cmd == OP_WRITE) wel_n = 1'b0;
        end else if (take) begin
            unique case (state)
                ST_IDLE: begin
                    cmd_n = byte_in;
                    acc_n = '0;
                    cnt_n = 2'(ADDR_BYTES);
                    case (byte_in)
                        OP_READ, OP_WRITE: state_n = ST_ADDR;
                        OP_RDSR:           state_n = ST_STATUS;
                        OP_WREN: begin wel_n = 1'b1; state_n = ST_NOP; end
                        OP_WRDI: begin wel_n = 1'b0; state_n = ST_NOP; end
                        default:           state_n = ST_NOP;
                    endcase
                end
                ST_ADDR: begin
                    acc_n = {acc[ACC_W-9:0], byte_in};
                    cnt_n = cnt - 2'd1;
                    if (cnt == 2'd1) state_n = (cmd == OP_READ) ? ST_READ : ST_WRITE;
                end
                ST_READ: begin
                    tx_n  = mem_rdata;
                    acc_n = acc + 1'b1;
                end
                ST_WRITE: begin
                    mem_we = wel;
                    acc_n  = acc + 1'b1;
                end
                ST_STATUS: tx_n = {6'b0, wel, 1'b0};
                ST_NOP:    tx_n = FILL;
                default:   state_n = ST_IDLE;
            endcase
            if (!hold) begin
                state_n = ST_IDLE;
                if (cmd_eff == OP_WRITE) wel_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd   <= '0;
            acc   <= '0;
            cnt   <= '0;
            wel   <= 1'b0;
        end else begin
            state <= state_n;
            cmd   <= cmd_n;
            acc   <= acc_n;
            cnt   <= cnt_n;
            wel   <= wel_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_out  <= FILL;
            byte_done <= 1'b0;
        end else begin
            byte_done <= take;
            if (take) byte_out <= tx_n;
        end
    end

    // R11: strobe follows exactly the accepted bytes
    p_done_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> byte_done);
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !byte_done);
    // R2: address bytes reply with fill
    p_addr_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state == ST_ADDR) |=> byte_out == FILL);
    // R5: write-phase bytes reply with fill
    p_write_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state == ST_WRITE) |=> byte_out == FILL);
    // R3: status reply carries only the latch bit
    p_status_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state == ST_STATUS) |=> (byte_out & 8'hFD) == 8'h00);
    // R6: releasing select during a write drops the latch
    p_wel_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && state != ST_IDLE && cmd == OP_WRITE) |=> !wel);
    // R9: a byte without hold closes the command
    p_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !hold) |=> state == ST_IDLE);
endmodule

// File: rtl/spi_save_mem.sv
module spi_save_mem
    import spi_save_pkg::*;
#(
    parameter int FLASH_MODE  = 0,
    parameter int MEM_DEPTH   = 256,
    localparam int ADDR_BYTES = (FLASH_MODE != 0) ? 3 : 2,
    localparam int AW         = $clog2(MEM_DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       hold,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic [7:0] byte_out,
    output logic       byte_done
);
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;

    spi_save_ctrl #(.ADDR_BYTES(ADDR_BYTES), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .hold(hold),
        .byte_valid(byte_valid), .byte_in(byte_in),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .byte_out(byte_out), .byte_done(byte_done)
    );

    spi_save_ram #(.DEPTH(MEM_DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );
endmodule

// File: tb/spi_save_mem_test.sv
module spi_save_mem_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = '0, hold = '0, bv = '0, bd;
    logic [7:0] bi [2];
    logic [7:0] bo [2];
    logic [7:0] ref_m [2][16];
    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_save_mem #(.FLASH_MODE(0), .MEM_DEPTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .sel(sel[0]), .hold(hold[0]),
        .byte_valid(bv[0]), .byte_in(bi[0]), .byte_out(bo[0]), .byte_done(bd[0]));
    spi_save_mem #(.FLASH_MODE(1), .MEM_DEPTH(16)) uut_f (
        .clk(clk), .rst_n(rst_n), .sel(sel[1]), .hold(hold[1]),
        .byte_valid(bv[1]), .byte_in(bi[1]), .byte_out(bo[1]), .byte_done(bd[1]));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int u, input logic [7:0] b, input logic h, output logic [7:0] r);
        @(negedge clk);
        sel[u] = 1'b1; hold[u] = h; bv[u] = 1'b1; bi[u] = b;
        @(negedge clk);
        bv[u] = 1'b0;
        chk("R11 done strobe", {7'b0, bd[u]}, 8'h01);
        r = bo[u];
    endtask

    task automatic release_sel(input int u);
        @(negedge clk); sel[u] = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_addr(input int u, input logic [23:0] a);
        logic [7:0] r;
        for (int k = (u != 0 ? 2 : 1); k >= 0; k--) begin
            xfer(u, 8'(a >> (8 * k)), 1'b1, r);
            chk("R2 address byte reply", r, 8'hFF);
        end
    endtask

    task automatic status(input int u, input logic [7:0] exp);
        logic [7:0] r;
        xfer(u, 8'h05, 1'b1, r);
        chk("R1 opcode reply", r, 8'hFF);
        xfer(u, 8'h00, 1'b1, r); chk("R3 status", r, exp);
        xfer(u, 8'h00, 1'b0, r); chk("R3 status repeat", r, exp);
        release_sel(u);
    endtask

    task automatic wr_seq(input int u, input logic [23:0] a, input int n, input int seed, input bit en);
        logic [7:0] r, d;
        if (en) begin xfer(u, 8'h06, 1'b0, r); chk("R1 wren reply", r, 8'hFF); end
        xfer(u, 8'h02, 1'b1, r);
        chk("R1 write opcode reply", r, 8'hFF);
        send_addr(u, a);
        for (int i = 0; i < n; i++) begin
            d = 8'((i * 37 + seed) & 255);
            xfer(u, d, (i == n - 1) ? 1'b0 : 1'b1, r);
            chk("R5 write byte reply", r, 8'hFF);
            if (en) ref_m[u][(int'(a) + i) % 16] = d;
        end
        release_sel(u);
    endtask

    task automatic rd_seq(input int u, input logic [23:0] a, input int n);
        logic [7:0] r;
        xfer(u, 8'h03, 1'b1, r);
        chk("R1 read opcode reply", r, 8'hFF);
        send_addr(u, a);
        for (int i = 0; i < n; i++) begin
            xfer(u, 8'h00, (i == n - 1) ? 1'b0 : 1'b1, r);
            chk("R4 R7 R8 read data", r, ref_m[u][(int'(a) + i) % 16]);
        end
        release_sel(u);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        bi[0] = 8'h00; bi[1] = 8'h00;
        for (int u = 0; u < 2; u++)
            for (int i = 0; i < 16; i++) ref_m[u][i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R11 reset done", {7'b0, bd[0]}, 8'h00);
        chk("R11 reset byte_out", bo[0], 8'hFF);
        chk("R11 reset byte_out flash", bo[1], 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: fresh array reads fill in both modes
        rd_seq(0, 24'h0, 16);
        rd_seq(1, 24'h0, 16);

        // R5: write without latch leaves memory unchanged
        wr_seq(0, 24'h3, 4, 11, 1'b0);
        rd_seq(0, 24'h0, 16);

        // R3: latch set and clear
        xfer(0, 8'h06, 1'b0, r); release_sel(0);
        status(0, 8'h02);
        xfer(0, 8'h04, 1'b0, r); release_sel(0);
        status(0, 8'h00);

        // R8: wrapping sweeps with discarded high address bits
        for (int s = 0; s < 16; s += 5) begin
            wr_seq(0, 24'h001230 | 24'(s), 6, s, 1'b1);
            status(0, 8'h00);  // R6 latch dropped after write
            rd_seq(0, 24'h0, 16);
            wr_seq(1, 24'hAB0000 | 24'(s), 6, s + 3, 1'b1);
            status(1, 8'h00);
            rd_seq(1, 24'h0, 16);
        end

        // R9: byte with hold low closes the command
        xfer(0, 8'h06, 1'b0, r);
        xfer(0, 8'h05, 1'b0, r);
        xfer(0, 8'h05, 1'b1, r); chk("R9 new opcode after hold low", r, 8'hFF);
        xfer(0, 8'h00, 1'b1, r); chk("R9 status after reopen", r, 8'h02);
        release_sel(0);
        // R9: select release mid-read, next byte is an opcode
        xfer(0, 8'h03, 1'b1, r); send_addr(0, 24'h0);
        xfer(0, 8'h00, 1'b1, r);
        release_sel(0);
        xfer(0, 8'h05, 1'b1, r); chk("R9 opcode after release", r, 8'hFF);
        xfer(0, 8'h00, 1'b0, r); chk("R9 status after release", r, 8'h02);
        release_sel(0);

        // R6: write aborted by select release before data
        xfer(0, 8'h02, 1'b1, r); send_addr(0, 24'h5);
        release_sel(0);
        status(0, 8'h00);
        rd_seq(0, 24'h0, 16);

        // R10: byte offered with select low is ignored
        @(negedge clk); bv[0] = 1'b1; bi[0] = 8'h06; hold[0] = 1'b0;
        @(negedge clk); bv[0] = 1'b0;
        chk("R10 no done while deselected", {7'b0, bd[0]}, 8'h00);
        @(negedge clk);
        status(0, 8'h00);

        // R1: unknown opcode yields fill
        xfer(0, 8'h9A, 1'b1, r); chk("R1 unknown opcode", r, 8'hFF);
        xfer(0, 8'h55, 1'b1, r); chk("R1 unknown opcode data", r, 8'hFF);
        @(negedge clk);
        chk("R11 done single cycle", {7'b0, bd[0]}, 8'h00);
        release_sel(0);

        finish_run();
    end
endmodule